// File: doc/BRIEF.md
# Circuit-Switched Port Crossbar

This block joins pairs of serial link ports on demand. Each port sits behind its own interface module. When that module asserts the port's active-low link enable, the port becomes a pending source. The first address value the module then delivers names the port it wants to reach. The switch checks that request and arbitrates it against any others in the same cycle. It then stores the pair in a per-source configuration entry and turns on the destination port's enable. From then on, the data and strobe lines of the two ports are cross-connected in both directions.

The connection stays up until the source releases its link enable. At that point the entry is cleared, and both ports are free for new requests. Requests that cannot be served get a one-cycle refusal pulse. These are requests for a busy port, requests for the source port itself, and losers of a same-cycle contest. A refused source remains pending, and the next address value it delivers is treated as a fresh request.

Top module: `cs_crossbar`

## Requirements
- R1: After reset, no connection exists, and `port_on`, `req_nak`, `ser_d_out` and `ser_s_out` are all zero.
- R2: A port is pending when its `lnk_en_n` bit is 0 and it is neither a source nor a destination of a connection. A pending port's `addr_vld` pulse carries the destination port index in slice `addr_in[i*AW +: AW]`, with AW = log2(NPORTS). If granted, that pulse creates the connection at the clock edge that samples it.
- R3: The destination's `port_on` bit rises one clock after the edge that sampled the granted request.
- R4: At most NPORTS/2 connections exist at once, and NPORTS/2 disjoint pairs can be active together.
- R5: When several pending sources request the same free destination at one edge, the lowest port index wins. Each other requester sees its `req_nak` bit high for exactly the one cycle after that edge.
- R6: When a connected source samples `lnk_en_n` = 1, its entry is cleared at that edge. The destination's `port_on` bit falls one clock later, and both ports can be used in new connections afterwards.
- R7: A request is refused with a `req_nak` pulse when its destination is already a source or destination of a connection, or when the destination's own `lnk_en_n` is 0.
- R8: A request whose address equals the requesting port's own index is refused with a `req_nak` pulse.
- R9: For a connected pair, the source's serial inputs appear on the destination's outputs, and the destination's inputs appear on the source's outputs, one clock after they are sampled.
- R10: An output port that belongs to no connection drives `ser_d_out` and `ser_s_out` low.
- R11: A refused source stays pending, and its next `addr_vld` pulse is arbitrated as a new request.
- R12: An `addr_vld` pulse from a port that is already connected changes neither the connection, nor `port_on`, nor `req_nak`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lnk_en_n | input | NPORTS | Active-low link enable from each port's interface module |
| addr_vld | input | NPORTS | Address value strobe per port |
| addr_in | input | NPORTS*AW | Destination index per port, port i in bits [i*AW +: AW] |
| ser_d_in | input | NPORTS | Serial data line from each port |
| ser_s_in | input | NPORTS | Serial strobe line from each port |
| port_on | output | NPORTS | Enable to each port that is a connection destination |
| req_nak | output | NPORTS | One-cycle refusal pulse per requesting port |
| ser_d_out | output | NPORTS | Serial data line to each port |
| ser_s_out | output | NPORTS | Serial strobe line to each port |

## Verification
The hardest case to reach is a pair of requests for one destination that land at the very same clock edge. A second case is a request that is turned down only because the wanted port has raised its own link enable, without yet being in any connection. The stimulus enables two sources a cycle ahead and then strobes both addresses on the same falling edge. It also leaves a would-be destination pending before another port asks for it. Teardown and later reuse of a freed port are covered by rebuilding a different pairing through that port after release.

// File: rtl/cs_xbar_pkg.sv
package cs_xbar_pkg;
  // Width of a port index; at least one bit.
  function automatic int unsigned idx_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/cs_xbar_arbiter.sv
module cs_xbar_arbiter #(
  parameter int NPORTS = 4,
  parameter int AW     = 2
) (
  input  logic [NPORTS-1:0]         req,
  input  logic [NPORTS-1:0][AW-1:0] req_dst,
  input  logic [NPORTS-1:0]         dst_busy,
  output logic [NPORTS-1:0]         grant,
  output logic [NPORTS-1:0]         refuse
);
  // Per destination, the lowest requesting index wins; self-addressed and
  // busy destinations win nothing.
  always_comb begin
    grant = '0;
    for (int j = 0; j < NPORTS; j++) begin
      logic taken;
      taken = 1'b0;
      for (int i = 0; i < NPORTS; i++) begin
        if (!taken && !dst_busy[j] && req[i] && (i != j) &&
            (req_dst[i] == AW'(j))) begin
          grant[i] = 1'b1;
          taken    = 1'b1;
        end
      end
    end
  end

  assign refuse = req & ~grant;
endmodule

// File: rtl/cs_xbar_cfg_file.sv
module cs_xbar_cfg_file #(
  parameter int NPORTS = 4,
  parameter int AW     = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NPORTS-1:0]         grant,
  input  logic [NPORTS-1:0][AW-1:0] req_dst,
  input  logic [NPORTS-1:0]         lnk_en_n,
  input  logic [NPORTS-1:0]         addr_vld,
  output logic [NPORTS-1:0]         conn_vld,
  output logic [NPORTS-1:0][AW-1:0] conn_dst
);
  // One entry per source port, indexed by source.
  always_ff @(posedge clk) begin
    if (rst) begin
      conn_vld <= '0;
      conn_dst <= '0;
    end else begin
      for (int i = 0; i < NPORTS; i++) begin
        if (lnk_en_n[i]) begin
          conn_vld[i] <= 1'b0;
          conn_dst[i] <= '0;
        end else if (grant[i]) begin
          conn_vld[i] <= 1'b1;
          conn_dst[i] <= req_dst[i];
        end
      end
    end
  end

  for (genvar a = 0; a < NPORTS; a++) begin : g_chk
    AST_CAPTURE_ON_ADDR: assert property (@(posedge clk) disable iff (rst)
      $rose(conn_vld[a]) |-> $past(addr_vld[a] && !lnk_en_n[a])); // R2
    AST_TEARDOWN: assert property (@(posedge clk) disable iff (rst)
      (conn_vld[a] && lnk_en_n[a]) |=> !conn_vld[a]); // R6
    AST_NO_SELF_ENTRY: assert property (@(posedge clk) disable iff (rst)
      conn_vld[a] |-> (conn_dst[a] != AW'(a))); // R8
    for (genvar b = a + 1; b < NPORTS; b++) begin : g_pair
      AST_DISTINCT_DST: assert property (@(posedge clk) disable iff (rst)
        (conn_vld[a] && conn_vld[b]) |-> (conn_dst[a] != conn_dst[b])); // R7
    end
  end
endmodule

// File: rtl/cs_xbar_route.sv
module cs_xbar_route #(
  parameter int NPORTS = 4,
  parameter int AW     = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NPORTS-1:0]         conn_vld,
  input  logic [NPORTS-1:0][AW-1:0] conn_dst,
  input  logic [NPORTS-1:0]         ser_d_in,
  input  logic [NPORTS-1:0]         ser_s_in,
  output logic [NPORTS-1:0]         ser_d_out,
  output logic [NPORTS-1:0]         ser_s_out
);
  logic [NPORTS-1:0]         hit;
  logic [NPORTS-1:0][AW-1:0] src;

  // Partner of each output: the source feeding a destination, or the
  // destination feeding back to its source.
  always_comb begin
    hit = '0;
    src = '0;
    for (int j = 0; j < NPORTS; j++) begin
      for (int i = 0; i < NPORTS; i++) begin
        if (conn_vld[i] && (conn_dst[i] == AW'(j))) begin
          hit[j] = 1'b1;
          src[j] = AW'(i);
        end
      end
      if (conn_vld[j]) begin
        hit[j] = 1'b1;
        src[j] = conn_dst[j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_d_out <= '0;
      ser_s_out <= '0;
    end else begin
      for (int j = 0; j < NPORTS; j++) begin
        ser_d_out[j] <= hit[j] ? ser_d_in[src[j]] : 1'b0;
        ser_s_out[j] <= hit[j] ? ser_s_in[src[j]] : 1'b0;
      end
    end
  end

  for (genvar j = 0; j < NPORTS; j++) begin : g_chk
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
      !$past(hit[j]) |-> (!ser_d_out[j] && !ser_s_out[j])); // R10
  end
endmodule

// File: rtl/cs_crossbar.sv
module cs_crossbar #(
  parameter  int NPORTS = 4,
  localparam int AW     = cs_xbar_pkg::idx_w(NPORTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NPORTS-1:0]    lnk_en_n,
  input  logic [NPORTS-1:0]    addr_vld,
  input  logic [NPORTS*AW-1:0] addr_in,
  input  logic [NPORTS-1:0]    ser_d_in,
  input  logic [NPORTS-1:0]    ser_s_in,
  output logic [NPORTS-1:0]    port_on,
  output logic [NPORTS-1:0]    req_nak,
  output logic [NPORTS-1:0]    ser_d_out,
  output logic [NPORTS-1:0]    ser_s_out
);
  logic [NPORTS-1:0][AW-1:0] req_dst;
  logic [NPORTS-1:0][AW-1:0] conn_dst;
  logic [NPORTS-1:0]         conn_vld, is_dst, pending, req, dst_busy;
  logic [NPORTS-1:0]         grant, refuse;

  for (genvar i = 0; i < NPORTS; i++) begin : g_addr
    assign req_dst[i] = addr_in[i*AW +: AW];
  end

  always_comb begin
    is_dst = '0;
    for (int i = 0; i < NPORTS; i++) begin
      for (int j = 0; j < NPORTS; j++) begin
        if (conn_vld[i] && (conn_dst[i] == AW'(j))) is_dst[j] = 1'b1;
      end
    end
  end

  assign pending  = ~lnk_en_n & ~conn_vld & ~is_dst;
  assign req      = addr_vld & pending;
  assign dst_busy = is_dst | conn_vld | ~lnk_en_n;

  cs_xbar_arbiter #(.NPORTS(NPORTS), .AW(AW)) u_arb (
    .req(req), .req_dst(req_dst), .dst_busy(dst_busy),
    .grant(grant), .refuse(refuse)
  );

  cs_xbar_cfg_file #(.NPORTS(NPORTS), .AW(AW)) u_cfg (
    .clk(clk), .rst(rst), .grant(grant), .req_dst(req_dst),
    .lnk_en_n(lnk_en_n), .addr_vld(addr_vld),
    .conn_vld(conn_vld), .conn_dst(conn_dst)
  );

  cs_xbar_route #(.NPORTS(NPORTS), .AW(AW)) u_route (
    .clk(clk), .rst(rst), .conn_vld(conn_vld), .conn_dst(conn_dst),
    .ser_d_in(ser_d_in), .ser_s_in(ser_s_in),
    .ser_d_out(ser_d_out), .ser_s_out(ser_s_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      port_on <= '0;
      req_nak <= '0;
    end else begin
      port_on <= is_dst;
      req_nak <= refuse;
    end
  end

  AST_PAIR_LIMIT: assert property (@(posedge clk) disable iff (rst)
    $countones(conn_vld) <= NPORTS / 2); // R4
  AST_ON_NOT_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (port_on & $past(conn_vld)) == '0); // R3
  AST_NAK_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    (req_nak & ~$past(addr_vld)) == '0); // R5
endmodule

// File: tb/cs_crossbar_tb.sv
module cs_crossbar_tb;
  localparam int N   = 4;
  localparam int AW  = $clog2(N);
  localparam int CLK = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  lnk_en_n = '1;
  logic [N-1:0]  addr_vld = '0;
  logic [N*AW-1:0] addr_in = '0;
  logic [N-1:0]  ser_d_in = '0, ser_s_in = '0;
  logic [N-1:0]  port_on, req_nak, ser_d_out, ser_s_out;

  int n_checks = 0, n_fail = 0;
  int partner [N];
  logic [2*N-1:0] sb_q [$];

  always #(CLK/2) clk = ~clk;

  cs_crossbar #(.NPORTS(N)) u_dut (
    .clk(clk), .rst(rst), .lnk_en_n(lnk_en_n), .addr_vld(addr_vld),
    .addr_in(addr_in), .ser_d_in(ser_d_in), .ser_s_in(ser_s_in),
    .port_on(port_on), .req_nak(req_nak),
    .ser_d_out(ser_d_out), .ser_s_out(ser_s_out)
  );

  task automatic check(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Monitor: compares one expected output item per streamed cycle.
  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      logic [2*N-1:0] e;
      e = sb_q.pop_front();
      check("R9/R10", "serial out {s,d}", {ser_s_out, ser_d_out}, e);
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  // Driver: random serial traffic, expected outputs from the bench pair map.
  task automatic stream(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      logic [N-1:0] ed, es;
      @(negedge clk);
      ser_d_in = N'($urandom);
      ser_s_in = N'($urandom);
      for (int j = 0; j < N; j++) begin
        ed[j] = (partner[j] >= 0) ? ser_d_in[partner[j]] : 1'b0;
        es[j] = (partner[j] >= 0) ? ser_s_in[partner[j]] : 1'b0;
      end
      sb_q.push_back({es, ed});
    end
    @(negedge clk);
    ser_d_in = '0;
    ser_s_in = '0;
  endtask

  // Strobe an address; returns at the falling edge after the sampling edge.
  task automatic request(input int src, input int dst);
    @(negedge clk);
    addr_vld[src] = 1'b1;
    addr_in[src*AW +: AW] = AW'(dst);
    @(negedge clk);
    addr_vld = '0;
  endtask

  task automatic pair(input int a, input int b);
    partner[a] = b;
    partner[b] = a;
  endtask

  task automatic unpair(input int a, input int b);
    partner[a] = -1;
    partner[b] = -1;
  endtask

  initial begin
    for (int j = 0; j < N; j++) partner[j] = -1;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    check("R1", "port_on after reset", port_on, 0);
    check("R1", "req_nak after reset", req_nak, 0);
    check("R1", "serial out after reset", {ser_s_out, ser_d_out}, 0);
    stream(8); // R10: nothing connected, all outputs low

    // R2/R3: connect 0 -> 2
    lnk_en_n[0] = 1'b0;
    request(0, 2);
    check("R2", "no nak for valid request", req_nak, 0);
    check("R3", "port_on before enable delay", port_on, 0);
    tick();
    check("R3", "destination enabled", port_on, 4'b0100);
    pair(0, 2);
    stream(12); // R9 both directions, R10 ports 1 and 3 low

    // R12: further address from connected source ignored
    request(0, 3);
    check("R12", "no nak on connected source", req_nak, 0);
    tick();
    check("R12", "port_on unchanged", port_on, 4'b0100);
    stream(6);

    // R7: busy destination (in connection, and enabled source)
    lnk_en_n[1] = 1'b0;
    tick();
    request(1, 2);
    check("R7", "nak for connected destination", req_nak, 4'b0010);
    tick();
    check("R7", "nak is one cycle", req_nak, 0);
    check("R7", "port_on unchanged", port_on, 4'b0100);
    request(1, 0);
    check("R7", "nak for connected source as destination", req_nak, 4'b0010);

    // R11/R4: retry to a free port, two pairs active
    request(1, 3);
    check("R11", "retry accepted", req_nak, 0);
    tick();
    check("R4", "two pairs enabled", port_on, 4'b1100);
    pair(1, 3);
    stream(12);

    // R6: teardown of 0 -> 2
    @(negedge clk);
    lnk_en_n[0] = 1'b1;
    tick();
    check("R6", "port_on one cycle after release", port_on, 4'b1100);
    tick();
    check("R6", "destination disabled", port_on, 4'b1000);
    unpair(0, 2);
    stream(8);
    @(negedge clk);
    lnk_en_n[1] = 1'b1;
    repeat (2) tick();
    check("R6", "all released", port_on, 0);
    unpair(1, 3);

    // R5: same-cycle contention for port 3
    lnk_en_n[0] = 1'b0;
    lnk_en_n[1] = 1'b0;
    tick();
    @(negedge clk);
    addr_vld[0] = 1'b1; addr_in[0*AW +: AW] = AW'(3);
    addr_vld[1] = 1'b1; addr_in[1*AW +: AW] = AW'(3);
    @(negedge clk);
    addr_vld = '0;
    check("R5", "lower index wins, other refused", req_nak, 4'b0010);
    tick();
    check("R5", "winner's destination enabled", port_on, 4'b1000);
    // R6 reuse: freed port 2 now joined with port 1
    request(1, 2);
    check("R6", "freed port reusable", req_nak, 0);
    tick();
    check("R6", "reuse enables port 2", port_on, 4'b1100);
    pair(0, 3);
    pair(1, 2);
    stream(12);
    @(negedge clk);
    lnk_en_n = '1;
    repeat (2) tick();
    unpair(0, 3);
    unpair(1, 2);

    // R8 self address, R7 destination with own enable asserted
    lnk_en_n[2] = 1'b0;
    lnk_en_n[3] = 1'b0;
    tick();
    request(2, 2);
    check("R8", "self address refused", req_nak, 4'b0100);
    tick();
    check("R8", "no port enabled", port_on, 0);
    request(2, 3);
    check("R7", "pending destination refused", req_nak, 4'b0100);
    tick();
    check("R7", "no port enabled", port_on, 0);
    stream(6);

    repeat (3) tick();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK * 200000);
    n_fail++;
    $display("FAIL watchdog expired (R1..R12 run incomplete)");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule